// File: doc/BRIEF.md
# Posted Request Queue Receiver

This block takes in write-request packets sent by a remote host. Each packet carries one fixed-size command entry (a number of data words) and names the ring slot it targets. The host must aim every write at the next free slot of an eight-slot ring. The block keeps the entry in that slot. Every write is answered one cycle later by a short acknowledgement packet. That packet echoes the slot number and tells the host whether the write was taken.

On the consumer side, a local controller does not get an interrupt. It finds new work only by polling. While its poll input is high, the block walks the ring in order, starting from the consumer index. It moves the first occupied slot it finds into a small local first-in first-out queue, at most one per cycle. Moving an entry frees its slot in the ring. The controller then drains the local queue with a valid/pop handshake. If the local queue is full, the transfer stalls and the ring slot keeps its entry.

Top module: `postq_receiver`

## Requirements
- R1: A write whose slot equals the producer index is stored when that slot is empty. The producer index is 0 after reset and steps by one on each accepted write. The acknowledgement then carries ack_err = 0.
- R2: Every cycle with wr_valid high yields exactly one acknowledgement in the next cycle (ack_valid = 1) with ack_slot equal to the written slot. No acknowledgement appears without a write.
- R3: A write to the producer index while that slot still holds an unconsumed entry is answered with ack_err = 1. The stored entry is unchanged and is later delivered with its original contents.
- R4: A write to any slot other than the producer index is answered with ack_err = 1. It stores nothing and leaves the producer index where it was.
- R5: Entries leave the ring only in cycles where poll_en is high. With poll_en low, lq_valid stays low however many entries are waiting.
- R6: A poll cycle scans the ring from the consumer index in increasing slot order, wrapping after the last slot. It takes the first occupied slot, at most one per cycle, and the consumer index becomes the taken slot plus one.
- R7: An entry taken in a poll cycle is on lq_data with lq_valid high in the next cycle, and its ring slot is empty from then on.
- R8: The local queue delivers entries in the order they were taken. An entry is removed at a clock edge where lq_valid and lq_pop are both high.
- R9: While the local queue holds LQ_DEPTH (default 4) entries, no slot is taken and the waiting slot keeps its entry. The transfer resumes after a pop.
- R10: After reset, ack_valid and lq_valid are low, every slot is empty, and both ring indexes are 0.
- R11: After slot NSLOT-1 (default 7) the producer index wraps to 0, and so does the consumer index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write-request packet present this cycle |
| wr_slot | input | $clog2(NSLOT) | Ring slot named by the packet address |
| wr_data | input | WORDS*WORD_W | Command entry, word 0 in the low bits |
| ack_valid | output | 1 | Acknowledgement packet present |
| ack_err | output | 1 | 1 = write refused, 0 = stored |
| ack_slot | output | $clog2(NSLOT) | Slot echoed from the write |
| poll_en | input | 1 | Controller polls the ring this cycle |
| lq_valid | output | 1 | Local queue has an entry at its head |
| lq_data | output | WORDS*WORD_W | Entry at the local queue head |
| lq_pop | input | 1 | Remove the head entry |

## Verification
The acknowledgement is registered, so it is due exactly one cycle after the write. A poll at edge N fills the local queue so that lq_valid shows after that edge. An entry written at edge N therefore reaches lq_valid at edge N+1 at the earliest if polling is on. The bench drives inputs on the falling edge and samples on the next falling edge, which is after exactly one rising edge. Waits for the local queue head use a bounded loop of falling edges. The bench tracks the producer index by itself, so it knows which writes must be refused, and it checks the order and contents of every delivered entry.

// File: rtl/postq_pkg.sv
package postq_pkg;

    typedef enum logic {
        ACK_OK  = 1'b0,
        ACK_ERR = 1'b1
    } ack_code_e;

    // next position on a ring of n places
    function automatic int inc_wrap(input int idx, input int n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/postq_ring_pick.sv
module postq_ring_pick #(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] occ,
    input  logic [SW-1:0]    start,
    output logic             found,
    output logic [SW-1:0]    pick
);
    int p;

    // walk backwards so the slot nearest to start wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        p     = 0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            p = int'(start) + k;
            if (p >= NSLOT) p = p - NSLOT;
            if (occ[p]) begin
                found = 1'b1;
                pick  = SW'(p);
            end
        end
    end

endmodule

// File: rtl/postq_slot_store.sv
module postq_slot_store
    import postq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int EW    = 128,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [SW-1:0]    wr_slot,
    input  logic [EW-1:0]    wr_data,
    input  logic             take,
    input  logic [SW-1:0]    take_slot,
    output logic [EW-1:0]    take_data,
    output logic [NSLOT-1:0] occ,
    output logic [SW-1:0]    cons_idx,
    output logic             ack_valid,
    output logic             ack_err,
    output logic [SW-1:0]    ack_slot
);
    typedef struct packed {
        logic [NSLOT-1:0]         vld;
        logic [NSLOT-1:0][EW-1:0] ent;
        logic [SW-1:0]            prod;
        logic [SW-1:0]            cons;
        logic                     ack_v;
        ack_code_e                ack_e;
        logic [SW-1:0]            ack_s;
    } store_t;

    store_t st_d, st_q;
    logic   accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_valid && (wr_slot == st_q.prod) && !st_q.vld[wr_slot];

        st_d.ack_v = wr_valid;
        st_d.ack_s = wr_slot;
        st_d.ack_e = accept ? ACK_OK : ACK_ERR;

        if (accept) begin
            st_d.vld[wr_slot] = 1'b1;
            st_d.ent[wr_slot] = wr_data;
            st_d.prod         = SW'(inc_wrap(int'(st_q.prod), NSLOT));
        end

        if (take) begin
            st_d.vld[take_slot] = 1'b0;
            st_d.cons           = SW'(inc_wrap(int'(take_slot), NSLOT));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_data = st_q.ent[take_slot];
    assign occ       = st_q.vld;
    assign cons_idx  = st_q.cons;
    assign ack_valid = st_q.ack_v;
    assign ack_err   = (st_q.ack_e == ACK_ERR);
    assign ack_slot  = st_q.ack_s;

endmodule

// File: rtl/postq_local_fifo.sv
module postq_local_fifo
    import postq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 128,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_push = push && (f_q.cnt != CW'(DEPTH));
        do_pop  = pop && (f_q.cnt != '0);

        if (do_push) begin
            f_d.mem[f_q.wr] = push_data;
            f_d.wr          = PW'(inc_wrap(int'(f_q.wr), DEPTH));
        end
        if (do_pop) begin
            f_d.rd = PW'(inc_wrap(int'(f_q.rd), DEPTH));
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign out_valid = (f_q.cnt != '0);
    assign out_data  = f_q.mem[f_q.rd];
    assign full      = (f_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/postq_receiver.sv
module postq_receiver #(
    parameter int NSLOT    = 8,
    parameter int WORDS    = 4,
    parameter int WORD_W   = 32,
    parameter int LQ_DEPTH = 4,
    localparam int SW      = $clog2(NSLOT),
    localparam int EW      = WORDS * WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [SW-1:0] wr_slot,
    input  logic [EW-1:0] wr_data,
    output logic          ack_valid,
    output logic          ack_err,
    output logic [SW-1:0] ack_slot,
    input  logic          poll_en,
    output logic          lq_valid,
    output logic [EW-1:0] lq_data,
    input  logic          lq_pop
);
    logic [NSLOT-1:0] slot_valid;
    logic [SW-1:0]    cons_idx;
    logic             found;
    logic [SW-1:0]    pick;
    logic             take;
    logic [EW-1:0]    take_data;
    logic             lq_full;

    assign take = poll_en && found && !lq_full;

    postq_slot_store #(.NSLOT(NSLOT), .EW(EW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .take      (take),
        .take_slot (pick),
        .take_data (take_data),
        .occ       (slot_valid),
        .cons_idx  (cons_idx),
        .ack_valid (ack_valid),
        .ack_err   (ack_err),
        .ack_slot  (ack_slot)
    );

    postq_ring_pick #(.NSLOT(NSLOT)) u_pick (
        .occ   (slot_valid),
        .start (cons_idx),
        .found (found),
        .pick  (pick)
    );

    postq_local_fifo #(.DEPTH(LQ_DEPTH), .W(EW)) u_lq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_data (take_data),
        .pop       (lq_pop),
        .out_valid (lq_valid),
        .out_data  (lq_data),
        .full      (lq_full)
    );

endmodule

// File: rtl/postq_checker.sv
module postq_checker #(
    parameter int NSLOT = 8,
    localparam int SW   = $clog2(NSLOT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [SW-1:0]    wr_slot,
    input logic             ack_valid,
    input logic             ack_err,
    input logic [SW-1:0]    ack_slot,
    input logic             poll_en,
    input logic [NSLOT-1:0] slot_valid,
    input logic             lq_full
);
    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (ack_valid && ack_slot == $past(wr_slot)));

    assert_no_stray_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !ack_valid);

    assert_occupied_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && slot_valid[wr_slot]) |=> ack_err);

    assert_occupied_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && slot_valid[wr_slot] && !poll_en) |=> slot_valid[$past(wr_slot)]);

    assert_poll_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_en |=> (($past(slot_valid) & ~slot_valid) == '0));

    assert_one_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(slot_valid) & ~slot_valid) <= 1);

    assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_en && lq_full) |=> (($past(slot_valid) & ~slot_valid) == '0));

endmodule

bind postq_receiver postq_checker #(.NSLOT(NSLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_slot    (wr_slot),
    .ack_valid  (ack_valid),
    .ack_err    (ack_err),
    .ack_slot   (ack_slot),
    .poll_en    (poll_en),
    .slot_valid (slot_valid),
    .lq_full    (lq_full)
);

// File: tb/sim_postq_receiver.sv
`timescale 1ns/1ps
module sim_postq_receiver;
    localparam int NSLOT = 8;
    localparam int SW    = 3;
    localparam int EW    = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [SW-1:0] wr_slot = '0;
    logic [EW-1:0] wr_data = '0;
    logic          ack_valid, ack_err;
    logic [SW-1:0] ack_slot;
    logic          poll_en = 1'b0;
    logic          lq_valid;
    logic [EW-1:0] lq_data;
    logic          lq_pop = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int prod   = 0;

    always #2 clk = ~clk;

    postq_receiver u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_slot(wr_slot), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_err(ack_err), .ack_slot(ack_slot),
        .poll_en(poll_en), .lq_valid(lq_valid), .lq_data(lq_data), .lq_pop(lq_pop)
    );

    function automatic logic [EW-1:0] mk(input int s, input int n);
        return {32'(n * 3 + 1), 32'hC0DE_0000 + 32'(n), 32'(s), 32'(n)};
    endfunction

    task automatic chk(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int s, input logic [EW-1:0] d, input bit exp_err, input string req);
        @(negedge clk);
        wr_valid = 1'b1; wr_slot = SW'(s); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk({req, " ack present (R2)"}, EW'(ack_valid), EW'(1));
        chk({req, " ack slot (R2)"}, EW'(ack_slot), EW'(s));
        chk({req, " ack code"}, EW'(ack_err), EW'(exp_err));
        if (!exp_err) prod = (prod == NSLOT - 1) ? 0 : prod + 1;
    endtask

    task automatic pop_expect(input logic [EW-1:0] d, input string req);
        for (int w = 0; w < 50 && !lq_valid; w++) @(negedge clk);
        chk({req, " head valid"}, EW'(lq_valid), EW'(1));
        chk({req, " head data"}, lq_data, d);
        lq_pop = 1'b1;
        @(negedge clk);
        lq_pop = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ack idle", EW'(ack_valid), EW'(0));
        chk("R10 local queue empty", EW'(lq_valid), EW'(0));
    endtask

    task automatic t_basic();
        poll_en = 1'b0;
        do_write(0, mk(0, 1), 1'b0, "R1 store slot0");
        repeat (3) @(negedge clk);
        chk("R5 no move without poll", EW'(lq_valid), EW'(0));
        chk("R2 no ack without write", EW'(ack_valid), EW'(0));
        poll_en = 1'b1;
        @(negedge clk);
        poll_en = 1'b0;
        chk("R7 head valid one cycle after poll", EW'(lq_valid), EW'(1));
        chk("R7 head data", lq_data, mk(0, 1));
        pop_expect(mk(0, 1), "R8 pop slot0");
    endtask

    task automatic t_wrong_slot();
        do_write(3, mk(3, 99), 1'b1, "R4 wrong slot");
        do_write(1, mk(1, 2), 1'b0, "R4 producer kept");
        poll_en = 1'b1;
        pop_expect(mk(1, 2), "R4 only good entry");
        repeat (4) @(negedge clk);
        chk("R4 refused entry never delivered", EW'(lq_valid), EW'(0));
        poll_en = 1'b0;
    endtask

    task automatic t_order();
        for (int k = 0; k < 4; k++) do_write(2 + k, mk(2 + k, 10 + k), 1'b0, "R1 batch");
        poll_en = 1'b1;
        @(negedge clk);
        poll_en = 1'b0;
        pop_expect(mk(2, 10), "R6 first in ring order");
        repeat (2) @(negedge clk);
        chk("R6 one move per poll cycle", EW'(lq_valid), EW'(0));
        poll_en = 1'b1;
        for (int k = 1; k < 4; k++) pop_expect(mk(2 + k, 10 + k), "R8 fifo order");
        repeat (2) @(negedge clk);
        chk("R8 queue drained", EW'(lq_valid), EW'(0));
        poll_en = 1'b0;
    endtask

    task automatic t_full();
        poll_en = 1'b1;
        do_write(6, mk(6, 20), 1'b0, "R1 slot6");
        do_write(7, mk(7, 21), 1'b0, "R1 slot7");
        do_write(0, mk(0, 22), 1'b0, "R11 wrap to slot0");
        do_write(1, mk(1, 23), 1'b0, "R1 slot1");
        do_write(2, mk(2, 24), 1'b0, "R9 fifth entry");
        repeat (10) @(negedge clk);
        pop_expect(mk(6, 20), "R9 full pop1");
        pop_expect(mk(7, 21), "R11 full pop2");
        pop_expect(mk(0, 22), "R11 full pop3");
        pop_expect(mk(1, 23), "R9 full pop4");
        pop_expect(mk(2, 24), "R9 stalled entry kept");
        poll_en = 1'b0;
    endtask

    task automatic t_occupied();
        for (int k = 0; k < NSLOT; k++) begin
            int s = (3 + k) % NSLOT;
            do_write(s, mk(s, 30 + k), 1'b0, "R11 fill ring");
        end
        chk("R11 producer wrapped back", EW'(prod), EW'(3));
        do_write(3, mk(3, 77), 1'b1, "R3 occupied slot");
        poll_en = 1'b1;
        for (int k = 0; k < NSLOT; k++) begin
            int s = (3 + k) % NSLOT;
            pop_expect(mk(s, 30 + k), "R3 original contents");
        end
        poll_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 no extra entry", EW'(lq_valid), EW'(0));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrong_slot();
        t_order();
        t_full();
        t_occupied();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule